// File: doc/BRIEF.md
# Banked Serial Port Register Front End

This block is the bus-facing register layer of a 16550-style serial port. A host reaches it through a byte-wide register interface with read and write strobes, a 3-bit offset and separate write and read data buses. A bank-select bit in the line control register decides what the two lowest offsets mean. With the bit clear, offset 0 reads the oldest received character and writes the next character to send. With the bit set, offsets 0 and 1 reach the low and high bytes of a 16-bit baud divisor.

The block holds a receive queue and a transmit queue, 16 entries each. It also holds the divisor, the line control register and the line status bits. The receive-side status describes the character at the receive head. A baud generator divides the clock by the divisor and emits a tick at 16 times the bit rate. A receiver (not part of this block) delivers characters and their error flags through a push port. A transmitter (not part of this block) takes bytes through a valid/take pair.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset the divisor is 0x0001, the line control register reads 0x00 (bank bit clear), both queues are empty, `tx_valid` is 0 and line status reads 0x20.
- R2: With the bank bit 0, a read at offset 0 returns the oldest received character on `bus_rdata` after the clock edge that samples the strobe, and removes it from the queue. A read with the receive queue empty returns 0x00 and removes nothing.
- R3: With the bank bit 0, a write at offset 0 appends the byte to the transmit queue. `tx_valid` is high while the queue holds data, and `tx_data` shows the oldest byte. `tx_take` removes that byte, so bytes leave in write order, bit 0 being the first bit to send.
- R4: A write never alters the received characters, and a read never alters the transmit queue.
- R5: With the bank bit 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. Such accesses touch neither queue.
- R6: `baud_tick` pulses for one cycle once every D clock cycles, where D is the programmed divisor. A divisor of 0x0000 gives a pulse every cycle, the same as 0x0001.
- R7: Line control bits 1:0 select the character length: 0 for 5 bits up to 3 for 8 bits. A received character is returned with the bits above that length forced to zero.
- R8: Line status bit 0 is data-ready (receive queue not empty). Bits 2, 3 and 4 are the parity-error, framing-error and break flags of the character at the receive head, and read as 0 when the queue is empty. Bit 5 is 1 when the transmit queue is empty. Reading status and then data therefore yields a matched pair.
- R9: A transmit write into a full queue (16 bytes) is dropped and sets line status bit 1. That bit stays set until a line status read returns it, and is then cleared.
- R10: The line control register sits at offset 3 and reads back as written, whatever the bank bit. Bit 7 is the bank bit. Line status sits at offset 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| rx_push | input | 1 | Receiver delivers a character |
| rx_char | input | 8 | Received character, bit 0 first received |
| rx_perr | input | 1 | Parity error of the delivered character |
| rx_ferr | input | 1 | Framing error of the delivered character |
| rx_brk | input | 1 | Break condition for the delivered character |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | 8 | Oldest byte in the transmit queue |
| tx_take | input | 1 | Transmitter takes the oldest byte |
| baud_tick | output | 1 | One-cycle pulse at 16x the bit rate |

## Verification
A vector table sends characters through the receive path under all four character lengths, each with a different mix of error flags. This separates padding faults from flag-mapping faults, and each status read is paired with the data read that follows it. Directed cases queue two characters with different flags, which shows whether the status follows the head entry or the newest entry. They also interleave host writes, transmitter takes and bank switching, which shows whether the two low offsets alias the right storage. The baud tick spacing is measured for divisors 4, 0 and 0x0103. This tells the zero-as-one rule apart from a plain off-by-one, and shows whether the high divisor byte takes part in the count.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DIVH = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_LCTL = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_LSTA = 3'd5;

  localparam int LCTL_BANK = 7;

  localparam int STA_READY = 0;
  localparam int STA_TXOVR = 1;
  localparam int STA_PERR  = 2;
  localparam int STA_FERR  = 3;
  localparam int STA_BRK   = 4;
  localparam int STA_TXEMP = 5;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] sel);
    return 8'hFF >> (2'd3 - sel);
  endfunction
endpackage

// File: rtl/sync_queue.sv
module sync_queue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PW = $clog2(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [PW:0]      used;
  logic             do_push, do_pop;

  assign empty   = (used == '0);
  assign full    = (used == (PW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end

  // R9: a push into a full queue without a pop leaves it full and unchanged
  a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(head)));

  // R2: popping an empty queue leaves it empty
  a_r2_empty_pop_noop: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] span;
  logic [DIV_W-1:0] cnt;
  logic             div_is_one;

  assign span       = (divisor == '0) ? DIV_W'(1) : divisor;
  assign div_is_one = (span == DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= span - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R6: a divisor of zero or one ticks on every cycle
  a_r6_unit_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (div_is_one && $past(div_is_one) && !$past(rst)) |-> tick);

  // R6: with a larger divisor, ticks never come back to back
  a_r6_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && !div_is_one) |=> !tick);
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_take,
  output logic              baud_tick
);
  localparam int ENT_W = $bits(rx_entry_t);
  localparam int DIV_W = 2 * DATA_W;

  logic [DATA_W-1:0] lctl_q, div_lo_q, div_hi_q;
  logic              txovr_q;
  logic              bank;

  logic              rd_data, wr_data, rd_stat;
  logic              rx_empty, rx_full, tx_empty, tx_full;
  logic [ENT_W-1:0]  rx_head_raw;
  rx_entry_t         rx_in, rx_head;
  logic [DATA_W-1:0] rx_shown, status, rd_mux;

  assign bank    = lctl_q[LCTL_BANK];
  assign rd_data = bus_rd && (bus_addr == OFS_DATA) && !bank;
  assign wr_data = bus_wr && (bus_addr == OFS_DATA) && !bank;
  assign rd_stat = bus_rd && (bus_addr == OFS_LSTA);

  assign rx_in = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_char};

  sync_queue #(.WIDTH(ENT_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .push  (rx_push),
    .din   (rx_in),
    .pop   (rd_data),
    .head  (rx_head_raw),
    .empty (rx_empty),
    .full  (rx_full)
  );

  sync_queue #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .push  (wr_data),
    .din   (bus_wdata),
    .pop   (tx_take),
    .head  (tx_data),
    .empty (tx_empty),
    .full  (tx_full)
  );

  assign tx_valid = !tx_empty;
  assign rx_head  = rx_empty ? '0 : rx_entry_t'(rx_head_raw);
  assign rx_shown = rx_head.data & len_mask(lctl_q[1:0]);

  always_comb begin
    status            = '0;
    status[STA_READY] = !rx_empty;
    status[STA_TXOVR] = txovr_q;
    status[STA_PERR]  = rx_head.perr;
    status[STA_FERR]  = rx_head.ferr;
    status[STA_BRK]   = rx_head.brk;
    status[STA_TXEMP] = tx_empty;
  end

  always_comb begin
    case (bus_addr)
      OFS_DATA: rd_mux = bank ? div_lo_q : rx_shown;
      OFS_DIVH: rd_mux = bank ? div_hi_q : '0;
      OFS_LCTL: rd_mux = lctl_q;
      OFS_LSTA: rd_mux = status;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lctl_q    <= '0;
      div_lo_q  <= 8'h01;
      div_hi_q  <= '0;
      txovr_q   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_wr) begin
        case (bus_addr)
          OFS_DATA: if (bank) div_lo_q <= bus_wdata;
          OFS_DIVH: if (bank) div_hi_q <= bus_wdata;
          OFS_LCTL: lctl_q <= bus_wdata;
          default:  ;
        endcase
      end
      if (wr_data && tx_full)   txovr_q <= 1'b1;
      else if (rd_stat)         txovr_q <= 1'b0;
    end
  end

  baud_divider #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .divisor ({div_hi_q, div_lo_q}),
    .tick    (baud_tick)
  );

  // R2: reading received data while the queue is empty returns zero
  a_r2_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rx_empty) |=> (bus_rdata == '0));

  // R4: a host write leaves the receive head untouched
  a_r4_write_keeps_rx: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && !rx_push) |=> ($stable(rx_empty) && $stable(rx_head_raw)));

  // R4: a host read leaves the transmit side untouched
  a_r4_read_keeps_tx: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && !tx_take) |=> ($stable(tx_valid) && $stable(tx_data)));

  // R9: dropping a byte on a full queue raises the sticky flag
  a_r9_sticky_set: assert property (@(posedge clk) disable iff (rst)
    (wr_data && tx_full) |=> status[STA_TXOVR]);

  // R8: data-ready is clear whenever the head flags must read zero
  a_r8_flags_need_data: assert property (@(posedge clk) disable iff (rst)
    !status[STA_READY] |-> (status[STA_BRK:STA_PERR] == '0));
endmodule

// File: tb/tb_uart_bank_regs.sv
module tb_uart_bank_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_push = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic [7:0] rx_char = '0;
  logic       tx_valid, tx_take = 1'b0, baud_tick;
  logic [7:0] tx_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_bank_regs dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_push(rx_push), .rx_char(rx_char), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_take(tx_take), .baud_tick(baud_tick)
  );

  // {len_sel[1:0], char[7:0], flags {brk,ferr,perr}[2:0], expected data[7:0]}
  localparam logic [20:0] VEC [6] = '{
    {2'd3, 8'hA5, 3'b000, 8'hA5},
    {2'd0, 8'hFF, 3'b001, 8'h1F},
    {2'd1, 8'hFF, 3'b010, 8'h3F},
    {2'd2, 8'hC3, 3'b100, 8'h43},
    {2'd3, 8'h00, 3'b111, 8'h00},
    {2'd2, 8'h80, 3'b000, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rx_send(input logic [7:0] c, input logic [2:0] f);
    @(negedge clk);
    rx_push = 1'b1; rx_char = c; {rx_brk, rx_ferr, rx_perr} = f;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic tx_pull();
    @(negedge clk);
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
  endtask

  task automatic tick_period(output int n);
    int guard = 0;
    repeat (3) @(negedge clk);
    while (!baud_tick && guard < 400) begin @(negedge clk); guard++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!baud_tick && n < 400);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int per;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 tx_valid", tx_valid, 0);
    rd(3'd5, v); chk("R1 status", v, 8'h20);
    rd(3'd3, v); chk("R1 line control", v, 8'h00);
    wr(3'd3, 8'h80);
    rd(3'd0, v); chk("R1 divisor low", v, 8'h01);
    rd(3'd1, v); chk("R1 divisor high", v, 8'h00);
    wr(3'd3, 8'h03);

    // R7 R8 R2: vector table
    for (int i = 0; i < 6; i++) begin
      wr(3'd3, {6'd0, VEC[i][20:19]});
      rx_send(VEC[i][18:11], VEC[i][10:8]);
      rd(3'd5, v); chk("R8 head status", v, 8'h21 | ({5'd0, VEC[i][10:8]} << 2));
      rd(3'd0, v); chk("R7 padded data", v, VEC[i][7:0]);
      rd(3'd5, v); chk("R2 popped", v, 8'h20);
    end
    wr(3'd3, 8'h03);

    // R8: status follows the head when two entries wait
    rx_send(8'h5A, 3'b001);
    rx_send(8'h3C, 3'b100);
    rd(3'd5, v); chk("R8 first pair status", v, 8'h25);
    rd(3'd0, v); chk("R2 first pair data", v, 8'h5A);
    rd(3'd5, v); chk("R8 second pair status", v, 8'h31);
    rd(3'd0, v); chk("R2 second pair data", v, 8'h3C);

    // R2: empty read
    rd(3'd0, v); chk("R2 empty read", v, 8'h00);
    rd(3'd5, v); chk("R2 empty status", v, 8'h20);

    // R4: isolation of the two directions
    rx_send(8'h11, 3'b000);
    wr(3'd0, 8'h77);
    chk("R3 tx_valid after write", tx_valid, 1);
    chk("R3 tx_data", tx_data, 8'h77);
    rd(3'd0, v); chk("R4 write kept rx", v, 8'h11);
    chk("R4 read kept tx", {tx_valid, tx_data}, {1'b1, 8'h77});
    tx_pull();
    chk("R3 drained", tx_valid, 0);

    // R3 R9: fill past capacity
    for (int i = 0; i < 17; i++) wr(3'd0, 8'(i * 3 + 1));
    rd(3'd5, v); chk("R9 overflow flag", v, 8'h02);
    rd(3'd5, v); chk("R9 flag cleared", v, 8'h00);
    for (int i = 0; i < 16; i++) begin
      chk("R3 tx order", {tx_valid, tx_data}, {1'b1, 8'(i * 3 + 1)});
      tx_pull();
    end
    chk("R9 extra byte dropped", tx_valid, 0);
    rd(3'd5, v); chk("R3 tx empty status", v, 8'h20);

    // R10 R5 R6: divisor bank
    wr(3'd3, 8'h83);
    rd(3'd3, v); chk("R10 lctl in bank 1", v, 8'h83);
    wr(3'd0, 8'h04);
    wr(3'd1, 8'h00);
    rd(3'd0, v); chk("R5 divisor low", v, 8'h04);
    rd(3'd1, v); chk("R5 divisor high", v, 8'h00);
    tick_period(per); chk("R6 period 4", per, 4);
    wr(3'd0, 8'h00);
    tick_period(per); chk("R6 zero acts as one", per, 1);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h03);
    tick_period(per); chk("R6 period 0x103", per, 259);
    chk("R5 bank write skipped tx", tx_valid, 0);
    wr(3'd3, 8'h03);
    rd(3'd3, v); chk("R10 lctl in bank 0", v, 8'h03);
    rd(3'd5, v); chk("R5 bank read kept rx", v, 8'h20);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule